// File: doc/BRIEF.md
# Extended bridge control register with internal-bus reset sequencer

This block holds a 16-bit control word for a PCI-to-PCI bridge companion device. The word selects whether writes may be posted, whether upstream memory reads count as prefetchable, and whether configuration cycles on the primary side are retried. It also holds the local processor in reset. Two of its fields take their values from strap pins while the primary reset is held, and keep the values sampled when that reset is released.

Software sets the internal-bus reset bit to start a self-clearing sequence. First the address-translation and DMA engines are allowed to finish work already in flight. The sequence waits until every engine reports idle, then holds a fixed blackout window of configuration cycles, then clears the bit by itself. While the sequence runs, the block raises an internal-bus reset to the engines and a configuration master-abort indication. Starting the sequence reloads the processor-hold bit to its strap default. The block is written through a plain register-write port with byte enables, and the current word is always visible on a read-data output.

Top module: `ebc_reg`

## Requirements
- R1: While `rst_n` is low the word loads 0x0008, with bit 2 set to `strap_retry` and bit 1 set to the inverse of `strap_run`. After release the word holds the values sampled on the last reset cycle. `ib_rst` and `cfg_mabort` are low.
- R2: A write updates the word only when `wr_addr` equals 0x40. Byte enable bit 0 gates bits 7:0 and byte enable bit 1 gates bits 15:8. A write to any other address, or with a lane disabled, leaves the affected bits unchanged.
- R3: Bits 15:13, 11, 7, 6 and 4 always read 0. Bits 12 and 10:8 are plain read/write storage that resets to 0.
- R4: Bit 0 drives `post_dis` (1 = no write posting). Bit 3 drives `up_pref` (1 = upstream reads prefetchable). Bit 2 drives `cfg_retry`. Each output follows its bit from the cycle after the write.
- R5: Bit 1 drives `cpu_hold`. Writing 0 to it clears it, and writing 1 to it has no effect.
- R6: Writing 1 to bit 5 while no sequence runs does three things from the next cycle. Bit 5 reads 1, `ib_rst` and `cfg_mabort` go high, and bit 1 reloads its strap default.
- R7: The sequence stays in its drain phase, with `ib_rst` high, for as long as any bit of `eng_busy` is high.
- R8: The blackout begins on the first clock edge that samples all of `eng_busy` low. `ib_rst` and `cfg_mabort` fall 32 clocks after that edge, and bit 5 reads 0 one clock later.
- R9: Writing 1 to bit 5 while a sequence runs neither restarts the timing nor reloads bit 1. The other bits of that write still apply.
- R10: Asserting `rst_n` during a sequence ends it at once and reloads the reset state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal-bus clock |
| rst_n | input | 1 | Primary reset, active low, synchronous |
| strap_retry | input | 1 | Strap: default of the configuration-retry bit |
| strap_run | input | 1 | Strap: high lets the processor run after reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Configuration offset of the write |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data |
| eng_busy | input | NUM_ENG | Busy flags from translation and DMA engines |
| rd_data | output | 16 | Current control word |
| post_dis | output | 1 | Write posting disabled |
| up_pref | output | 1 | Upstream memory reads prefetchable |
| cfg_retry | output | 1 | Retry all primary configuration cycles |
| cpu_hold | output | 1 | Hold processor in reset |
| ib_rst | output | 1 | Internal-bus reset to the engines |
| cfg_mabort | output | 1 | Configuration cycles complete as master abort |

## Verification
Every word and control output moves on the first edge after a write, so the bench drives a write on a falling edge and samples on the next falling edge. The sequence outputs rise one edge after the starting write. They fall on the 33rd edge counted from the first edge that sees all engines idle, and bit 5 clears on the 34th. The bench counts falling edges from the moment it drops the busy flags, and samples just before and just after each of those edges. A repeated start is issued inside the blackout window, and the same edge counts confirm that it does not stretch the window.

// File: rtl/ebc_reg.sv
module ebc_reg #(
  parameter int          NUM_ENG   = 4,
  parameter int          BLACK_CYC = 32,
  parameter logic [7:0]  REG_OFS   = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_retry,
  input  logic               strap_run,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [1:0]         wr_be,
  input  logic [15:0]        wr_data,
  input  logic [NUM_ENG-1:0] eng_busy,
  output logic [15:0]        rd_data,
  output logic               post_dis,
  output logic               up_pref,
  output logic               cfg_retry,
  output logic               cpu_hold,
  output logic               ib_rst,
  output logic               cfg_mabort
);
  localparam int CW = (BLACK_CYC > 1) ? $clog2(BLACK_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_BLACK, S_DONE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        r_pd, r_pf, r_rty, r_hold, hold_dflt;
  logic [3:0]  r_hi;

  wire hit_lo = wr_en && (wr_addr == REG_OFS) && wr_be[0];
  wire hit_hi = wr_en && (wr_addr == REG_OFS) && wr_be[1];
  wire start  = hit_lo && wr_data[5] && (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pd      <= 1'b0;
      r_pf      <= 1'b1;
      r_rty     <= strap_retry;
      hold_dflt <= !strap_run;
      r_hold    <= !strap_run;
      r_hi      <= '0;
    end else begin
      if (hit_lo) begin
        r_pd  <= wr_data[0];
        r_rty <= wr_data[2];
        r_pf  <= wr_data[3];
      end
      if (start)
        r_hold <= hold_dflt;
      else if (hit_lo && !wr_data[1])
        r_hold <= 1'b0;
      if (hit_hi)
        r_hi <= {wr_data[12], wr_data[10:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:  if (start) st <= S_DRAIN;
        S_DRAIN: if (!(|eng_busy)) begin
                   st  <= S_BLACK;
                   cnt <= '0;
                 end
        S_BLACK: if (cnt == CW'(BLACK_CYC - 1)) st <= S_DONE;
                 else cnt <= cnt + 1'b1;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_data = {3'b000, r_hi[3], 1'b0, r_hi[2:0], 2'b00, (st != S_IDLE),
                    1'b0, r_pf, r_rty, r_hold, r_pd};

  assign post_dis   = r_pd;
  assign up_pref    = r_pf;
  assign cfg_retry  = r_rty;
  assign cpu_hold   = r_hold;
  assign ib_rst     = (st == S_DRAIN) || (st == S_BLACK);
  assign cfg_mabort = (st == S_DRAIN) || (st == S_BLACK);
endmodule

module ebc_reg_chk #(
  parameter int NUM_ENG   = 4,
  parameter int BLACK_CYC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [NUM_ENG-1:0] eng_busy,
  input logic [15:0]        rd_data,
  input logic               cpu_hold,
  input logic               ib_rst
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                       run_len <= '0;
    else if (!ib_rst)                 run_len <= '0;
    else if (run_len != 16'hFFFF)     run_len <= run_len + 16'd1;
  end

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rd_data[3:0]) && $stable(rd_data[12:8])));

  // R6
  seq_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ib_rst) |-> $past(wr_en));

  // R5
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |-> $rose(ib_rst));

  // R7
  drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_rst && (|eng_busy)) |=> ib_rst);

  // R8
  blackout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ib_rst) |-> (run_len >= 16'(BLACK_CYC)));

  // R8
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ib_rst) |-> (rd_data[5] ##1 !rd_data[5]));
endmodule

bind ebc_reg ebc_reg_chk #(.NUM_ENG(NUM_ENG), .BLACK_CYC(BLACK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .eng_busy(eng_busy),
  .rd_data(rd_data), .cpu_hold(cpu_hold), .ib_rst(ib_rst)
);

// File: tb/ebc_reg_tb.sv
module ebc_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_retry = 1'b1;
  logic        strap_run = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  eng_busy = '0;
  logic [15:0] rd_data;
  logic        post_dis, up_pref, cfg_retry, cpu_hold, ib_rst, cfg_mabort;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  ebc_reg u_dut (
    .clk(clk), .rst_n(rst_n), .strap_retry(strap_retry), .strap_run(strap_run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .eng_busy(eng_busy), .rd_data(rd_data), .post_dis(post_dis), .up_pref(up_pref),
    .cfg_retry(cfg_retry), .cpu_hold(cpu_hold), .ib_rst(ib_rst), .cfg_mabort(cfg_mabort)
  );

  // {addr[41:34], be[33:32], data[31:16], expected word[15:0]}, from reset word 0x000E
  localparam logic [41:0] VEC [0:7] = '{
    {8'h40, 2'b11, 16'h0000, 16'h0000},  // R2 R5 clear all, hold cleared
    {8'h40, 2'b11, 16'hFFDF, 16'h170D},  // R3 R5 reserved stay 0, hold not settable
    {8'h40, 2'b01, 16'h0000, 16'h1700},  // R2 low lane only
    {8'h40, 2'b10, 16'h0000, 16'h0000},  // R2 high lane only
    {8'h44, 2'b11, 16'h1709, 16'h0000},  // R2 wrong offset ignored
    {8'h40, 2'b00, 16'hFFFF, 16'h0000},  // R2 no lanes, no start
    {8'h40, 2'b01, 16'h0009, 16'h0009},  // R4 posting off, prefetch on
    {8'h40, 2'b10, 16'hFFFF, 16'h1709}   // R3 upper storage bits
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic rty, input logic run);
    strap_retry = rty; strap_run = run; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset(1'b1, 1'b0);
    chk("R1 reset word", rd_data, 16'h000E);
    chk("R1 reset outputs", {12'h0, ib_rst, cfg_mabort, cpu_hold, cfg_retry}, 16'h0003);

    foreach (VEC[i]) begin
      wr(VEC[i][41:34], VEC[i][33:32], VEC[i][31:16]);
      chk("R2 R3 word", rd_data, VEC[i][15:0]);
      chk("R4 R5 outputs", {12'h0, cpu_hold, cfg_retry, up_pref, post_dis},
          {12'h0, VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][0]});
    end
    chk("R3 reserved zero", rd_data & 16'hE8D0, 16'h0000);

    // sequence: hold cleared, engines busy
    wr(8'h40, 2'b01, 16'h0001);
    chk("R5 hold cleared", {15'h0, cpu_hold}, 16'h0000);
    eng_busy = 4'b0101;
    wr(8'h40, 2'b01, 16'h0021);
    chk("R6 start word", rd_data, 16'h1723);
    chk("R6 start outputs", {14'h0, ib_rst, cfg_mabort}, 16'h0003);
    repeat (5) @(negedge clk);
    chk("R7 drain held", {14'h0, ib_rst, cfg_mabort}, 16'h0003);
    eng_busy = 4'b0000;
    for (int i = 0; i < 32; i++) begin
      if (i == 10) begin
        wr_en = 1'b1; wr_addr = 8'h40; wr_be = 2'b01; wr_data = 16'h0022;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R8 R9 still in blackout", {14'h0, ib_rst, cfg_mabort}, 16'h0003);
    chk("R9 restart write bits applied", rd_data, 16'h1722);
    @(negedge clk);
    chk("R8 blackout end", {14'h0, ib_rst, cfg_mabort}, 16'h0000);
    chk("R8 bit5 still set", {15'h0, rd_data[5]}, 16'h0001);
    @(negedge clk);
    chk("R8 bit5 self-cleared", rd_data, 16'h1702);

    // R9 hold not reloaded by a repeated start
    wr(8'h40, 2'b01, 16'h0020);
    chk("R6 second start", {14'h0, cpu_hold, ib_rst}, 16'h0003);
    wr(8'h40, 2'b01, 16'h0020);
    chk("R5 hold clear mid sequence", {15'h0, cpu_hold}, 16'h0000);
    wr(8'h40, 2'b01, 16'h0020);
    chk("R9 hold not reloaded", {14'h0, cpu_hold, ib_rst}, 16'h0001);

    // R10 reset mid sequence, opposite straps
    do_reset(1'b0, 1'b1);
    chk("R10 reset aborts sequence", {14'h0, ib_rst, cfg_mabort}, 16'h0000);
    chk("R1 R10 reset word alt straps", rd_data, 16'h0008);
    wr(8'h40, 2'b01, 16'h0020);
    chk("R6 default zero hold", {14'h0, cpu_hold, ib_rst}, 16'h0001);

    finish_run();
  end
endmodule